// File: doc/BRIEF.md
# SPI Mode Control Register with Low-Power Entry Sequencer

This block is the serial command register of a relay-driver companion device. A host microcontroller talks to it over an SPI slave link (mode 0, MSB first). Every transfer shifts one command byte in and one status byte out. A command byte carries the bus slew/baud choice, a pull-up disconnect bit for the low-power states, enables for three high-side switches, and a two-bit operating-mode field. The block registers these fields and drives them as decoded outputs. It also emits a one-clock watchdog-clear strobe and qualifies entry into Sleep or Stop.

The host cannot put the device into a low-power state with a single byte. The low-power command must arrive in two consecutive, bit-identical, well-formed frames. The block holds the first one as pending and commits only on the second. A malformed frame, or any other well-formed frame, drops the pending request. Reset works in two domains. Power-on reset clears everything. The soft reset leaves the pull-up disconnect bit alone. The first status byte read after either reset reports battery failure in place of the low-voltage flag.

The SPI pins are oversampled in the system clock domain through a synchronizer chain, so SCK must be several system clocks slower than `clk`.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset every control output is 0 (`spd_sel`, `pu_off`, `hs_en`, `mode_sel`, `wd_clr`, `sleep_req`, `stop_req`), and `miso_en` is 0 while `cs_n` is high.
- R2: A frame with exactly 8 SCK rising edges while `cs_n` is low is valid. When `cs_n` rises, a valid non-low-power byte loads `spd_sel` from bits 7:6 (00 normal 20 kbps, 01 slow 10 kbps, 10 fast download 100 kbps, 11 low-power request), `pu_off` from bit 5, `hs_en[2:0]` from bits 4:2 (bit 4 = switch 3), and `mode_sel` from bits 1:0.
- R3: A valid frame with mode field 10 (watchdog clear) pulses `wd_clr` high for exactly one clock and leaves `mode_sel` at 11 (Run).
- R4: The low-power command is a byte with bits 7:6 = 11, bits 4:2 = 000 and bit 1 = 0. Bit 0 = 0 selects Sleep and bit 0 = 1 selects Stop. A single such frame changes no output.
- R5: Two consecutive valid frames carrying the same low-power byte apply that byte. On the second frame, `sleep_req` goes high for bit 0 = 0 or `stop_req` for bit 0 = 1. The two flags are never high together.
- R6: A valid frame that does not repeat the pending low-power byte cancels the pending request. If it is not itself a low-power command, it is applied normally and clears `sleep_req` and `stop_req`.
- R7: A frame with any SCK count other than 8 changes no output and cancels a pending low-power request.
- R8: Soft reset `srst` clears every control output and the pending request, but leaves `pu_off` unchanged.
- R9: Power-on reset `por` clears every control output, `pu_off` included.
- R10: The returned byte carries `stat_src[6:0]` in bits 6:0 and their OR in bit 7. These values are sampled when `cs_n` falls. MISO is valid before the first SCK rise and advances on each SCK fall.
- R11: In the first frame after any reset, bit 4 of the returned byte is `batt_fail` rather than `stat_src[4]`, and bit 7 uses that substituted value. Later frames use `stat_src[4]`.
- R12: `miso_en` is high while a frame is in progress and low while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| srst | input | 1 | Soft reset, synchronous, active high |
| sck | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data in, MSB first |
| miso | output | 1 | SPI data out |
| miso_en | output | 1 | Output enable for the MISO pad driver |
| stat_src | input | 7 | Status/interrupt source flags; bit 4 is the low-voltage flag |
| batt_fail | input | 1 | Battery-fail flag, reported in the first read after reset |
| spd_sel | output | 2 | Bus slew/baud selection |
| pu_off | output | 1 | 1 disconnects the bus pull-up in Sleep/Stop |
| hs_en | output | 3 | High-side switch enables |
| mode_sel | output | 2 | Registered operating-mode field |
| wd_clr | output | 1 | One-clock watchdog-clear strobe |
| sleep_req | output | 1 | Confirmed Sleep entry |
| stop_req | output | 1 | Confirmed Stop entry |

## Verification
Random command bytes are mixed with deliberately built low-power pairs. The pairs come in four kinds: identical, differing only in the pull-up bit, Sleep followed by Stop, and split by a short or long frame. These tell true confirmation apart from a sequencer that commits on the first request or on any second low-power byte. Frames of 7 and 9 SCK edges separate exact-count validation from a design that only checks for at least eight. Soft and power-on resets are injected between frames with `pu_off` set, which shows whether each reset reaches its own bit. They also arm the battery-fail substitution, which distinguishes a first-read flag from one that never clears.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

    localparam int BYTE_W  = 8;
    localparam int SRC_W   = 7;
    localparam int NUM_HS  = 3;
    localparam int LV_BIT  = 4;
    localparam int CNT_W   = 4;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_SLOW   = 2'b01,
        SPD_FAST   = 2'b10,
        SPD_LOWPWR = 2'b11
    } spd_e;

    typedef enum logic [1:0] {
        MD_SLEEP = 2'b00,
        MD_STOP  = 2'b01,
        MD_WDCLR = 2'b10,
        MD_RUN   = 2'b11
    } mode_e;

    typedef struct packed {
        spd_e              spd;
        logic              pu_off;
        logic [NUM_HS-1:0] hs;
        mode_e             mode;
    } ctrl_t;

    typedef struct packed {
        logic              evt;
        logic              ok;
        logic [BYTE_W-1:0] data;
    } frame_t;

    function automatic ctrl_t unpack_cmd(input logic [BYTE_W-1:0] b);
        ctrl_t c;
        c.spd    = spd_e'(b[7:6]);
        c.pu_off = b[5];
        c.hs     = b[4:2];
        c.mode   = mode_e'(b[1:0]);
        return c;
    endfunction

    function automatic logic is_lp_cmd(input logic [BYTE_W-1:0] b);
        return (b[7:6] == SPD_LOWPWR) && (b[4:2] == '0) && (b[1] == 1'b0);
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(
        input logic [SRC_W-1:0] src,
        input logic             first,
        input logic             bf
    );
        logic [SRC_W-1:0] s;
        s         = src;
        s[LV_BIT] = first ? bf : src[LV_BIT];
        return {|s, s};
    endfunction

endpackage

// File: rtl/lmc_spi_front.sv
module lmc_spi_front
    import lmc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              cs_fall,
    output logic              miso,
    output logic              miso_en,
    output frame_t            frame
);
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    // index 0: cs_n, 1: sck, 2: mosi
    logic [2:0] stg [SYNC_STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[gi] <= 3'b001;
                end else if (gi == 0) begin
                    stg[gi] <= {mosi, sck, cs_n};
                end else begin
                    stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    logic cs_s, sck_s, mosi_s;
    assign cs_s   = stg[SYNC_STAGES-1][0];
    assign sck_s  = stg[SYNC_STAGES-1][1];
    assign mosi_s = stg[SYNC_STAGES-1][2];

    logic cs_d, sck_d;
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
        end
    end

    logic cs_rise, sck_rise, sck_fall;
    assign cs_fall  =  cs_d & ~cs_s;
    assign cs_rise  = ~cs_d &  cs_s;
    assign sck_rise = ~sck_d &  sck_s & ~cs_s;
    assign sck_fall =  sck_d & ~sck_s & ~cs_s;

    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic [CNT_W-1:0]  edge_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh    <= '0;
            edge_cnt <= '0;
        end else if (cs_fall) begin
            edge_cnt <= '0;
        end else if (sck_rise) begin
            rx_sh <= {rx_sh[BYTE_W-2:0], mosi_s};
            if (edge_cnt != CNT_W'(CNT_MAX)) begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
        end else if (cs_fall) begin
            tx_sh <= tx_byte;
        end else if (sck_fall) begin
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end

    assign miso    = ~cs_s & tx_sh[BYTE_W-1];
    assign miso_en = ~cs_s;

    always_comb begin
        frame.evt  = cs_rise;
        frame.ok   = (edge_cnt == CNT_W'(BYTE_W));
        frame.data = rx_sh;
    end

endmodule

// File: rtl/lmc_status.sv
module lmc_status
    import lmc_pkg::*;
(
    input  logic              clk,
    input  logic              any_rst,
    input  logic              cs_fall,
    input  logic [SRC_W-1:0]  stat_src,
    input  logic              batt_fail,
    output logic [BYTE_W-1:0] tx_byte
);
    logic first_rd;

    always_ff @(posedge clk) begin
        if (any_rst) begin
            first_rd <= 1'b1;
        end else if (cs_fall) begin
            first_rd <= 1'b0;
        end
    end

    assign tx_byte = pack_status(stat_src, first_rd, batt_fail);

endmodule

// File: rtl/lmc_ctrl_regs.sv
module lmc_ctrl_regs
    import lmc_pkg::*;
(
    input  logic   clk,
    input  logic   por,
    input  logic   srst,
    input  frame_t frame,
    output ctrl_t  ctrl,
    output logic   wd_clr,
    output logic   sleep_req,
    output logic   stop_req
);
    logic              pend;
    logic [BYTE_W-1:0] pend_b;
    ctrl_t             cmd;
    logic              lp, repeat_hit;

    assign cmd        = unpack_cmd(frame.data);
    assign lp         = is_lp_cmd(frame.data);
    assign repeat_hit = pend && (pend_b == frame.data);

    // pull-up bit: power-on reset domain only
    always_ff @(posedge clk) begin
        if (por) begin
            ctrl.pu_off <= 1'b0;
        end else if (!srst && frame.evt && frame.ok && (!lp || repeat_hit)) begin
            ctrl.pu_off <= cmd.pu_off;
        end
    end

    // remaining fields and sequencer: either reset
    always_ff @(posedge clk) begin
        if (por || srst) begin
            ctrl.spd  <= SPD_NORMAL;
            ctrl.hs   <= '0;
            ctrl.mode <= MD_SLEEP;
            pend      <= 1'b0;
            pend_b    <= '0;
            wd_clr    <= 1'b0;
            sleep_req <= 1'b0;
            stop_req  <= 1'b0;
        end else begin
            wd_clr <= 1'b0;
            if (frame.evt) begin
                if (!frame.ok) begin
                    pend <= 1'b0;
                end else if (lp) begin
                    if (repeat_hit) begin
                        ctrl.spd  <= cmd.spd;
                        ctrl.hs   <= cmd.hs;
                        ctrl.mode <= cmd.mode;
                        pend      <= 1'b0;
                        sleep_req <= (cmd.mode == MD_SLEEP);
                        stop_req  <= (cmd.mode == MD_STOP);
                    end else begin
                        pend   <= 1'b1;
                        pend_b <= frame.data;
                    end
                end else begin
                    pend      <= 1'b0;
                    ctrl.spd  <= cmd.spd;
                    ctrl.hs   <= cmd.hs;
                    sleep_req <= 1'b0;
                    stop_req  <= 1'b0;
                    if (cmd.mode == MD_WDCLR) begin
                        ctrl.mode <= MD_RUN;
                        wd_clr    <= 1'b1;
                    end else begin
                        ctrl.mode <= cmd.mode;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
    import lmc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 por,
    input  logic                 srst,
    input  logic                 sck,
    input  logic                 cs_n,
    input  logic                 mosi,
    output logic                 miso,
    output logic                 miso_en,
    input  logic [SRC_W-1:0]     stat_src,
    input  logic                 batt_fail,
    output logic [1:0]           spd_sel,
    output logic                 pu_off,
    output logic [NUM_HS-1:0]    hs_en,
    output logic [1:0]           mode_sel,
    output logic                 wd_clr,
    output logic                 sleep_req,
    output logic                 stop_req
);
    logic              any_rst;
    logic              cs_fall;
    logic [BYTE_W-1:0] tx_byte;
    frame_t            frame;
    ctrl_t             ctrl;

    assign any_rst = por | srst;

    lmc_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst     (any_rst),
        .sck     (sck),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .tx_byte (tx_byte),
        .cs_fall (cs_fall),
        .miso    (miso),
        .miso_en (miso_en),
        .frame   (frame)
    );

    lmc_status u_status (
        .clk       (clk),
        .any_rst   (any_rst),
        .cs_fall   (cs_fall),
        .stat_src  (stat_src),
        .batt_fail (batt_fail),
        .tx_byte   (tx_byte)
    );

    lmc_ctrl_regs u_regs (
        .clk       (clk),
        .por       (por),
        .srst      (srst),
        .frame     (frame),
        .ctrl      (ctrl),
        .wd_clr    (wd_clr),
        .sleep_req (sleep_req),
        .stop_req  (stop_req)
    );

    assign spd_sel  = ctrl.spd;
    assign pu_off   = ctrl.pu_off;
    assign hs_en    = ctrl.hs;
    assign mode_sel = ctrl.mode;

endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk (
    input logic       clk,
    input logic       por,
    input logic       srst,
    input logic       cs_n,
    input logic       miso_en,
    input logic [1:0] spd_sel,
    input logic       pu_off,
    input logic [2:0] hs_en,
    input logic [1:0] mode_sel,
    input logic       wd_clr,
    input logic       sleep_req,
    input logic       stop_req
);
    AST_WD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (por || srst)
        wd_clr |=> !wd_clr);  // R3
    AST_WD_KEEPS_RUN: assert property (@(posedge clk) disable iff (por || srst)
        wd_clr |-> mode_sel == 2'b11);  // R3
    AST_LP_EXCLUSIVE: assert property (@(posedge clk) disable iff (por)
        !(sleep_req && stop_req));  // R5
    AST_LP_SWITCHES_OFF: assert property (@(posedge clk) disable iff (por || srst)
        (sleep_req || stop_req) |-> (hs_en == 3'b000 && spd_sel == 2'b11));  // R5
    AST_SRST_KEEPS_PU: assert property (@(posedge clk) disable iff (por)
        srst |=> pu_off == $past(pu_off));  // R8
    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (por)
        srst |=> (hs_en == 3'b000 && !sleep_req && !stop_req && !wd_clr));  // R8
    AST_POR_CLEARS: assert property (@(posedge clk) disable iff (srst)
        por |=> (!pu_off && hs_en == 3'b000 && spd_sel == 2'b00 && mode_sel == 2'b00));  // R9
    AST_EN_IDLE: assert property (@(posedge clk) disable iff (por || srst)
        $rose(miso_en) |-> $past(!cs_n, 2));  // R12
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
    .clk       (clk),
    .por       (por),
    .srst      (srst),
    .cs_n      (cs_n),
    .miso_en   (miso_en),
    .spd_sel   (spd_sel),
    .pu_off    (pu_off),
    .hs_en     (hs_en),
    .mode_sel  (mode_sel),
    .wd_clr    (wd_clr),
    .sleep_req (sleep_req),
    .stop_req  (stop_req)
);

// File: tb/sim_lin_mode_ctrl.sv
`timescale 1ns/1ps
module sim_lin_mode_ctrl;
    logic       clk = 1'b0;
    logic       por = 1'b1, srst = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       miso, miso_en;
    logic [6:0] stat_src = '0;
    logic       batt_fail = 1'b0;
    logic [1:0] spd_sel, mode_sel;
    logic       pu_off, wd_clr, sleep_req, stop_req;
    logic [2:0] hs_en;

    always #4 clk = ~clk;

    lin_mode_ctrl u0 (.*);

    int checks = 0, errors = 0;
    bit done = 0;
    int wd_seen = 0;

    always @(posedge clk) if (wd_clr) wd_seen <= wd_seen + 1;

    // model state
    logic [1:0] e_spd = 0, e_mode = 0;
    logic       e_pu = 0, e_sl = 0, e_st = 0, e_pend = 0, e_first = 1;
    logic [2:0] e_hs = 0;
    logic [7:0] e_pb = 0;
    int         e_wd = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic lp_form(input logic [7:0] b);
        return b[7:6] == 2'b11 && b[4:2] == 3'b000 && b[1] == 1'b0;
    endfunction

    function automatic logic [7:0] exp_status(input logic [6:0] s, input logic f, input logic bf);
        logic [6:0] t = s;
        if (f) t[4] = bf;
        return {|t, t};
    endfunction

    task automatic model_frame(input int n, input logic [7:0] b);
        e_first = 0;
        if (n != 8) e_pend = 0;
        else if (lp_form(b)) begin
            if (e_pend && b == e_pb) begin
                e_spd = b[7:6]; e_pu = b[5]; e_hs = b[4:2]; e_mode = b[1:0];
                e_pend = 0; e_sl = !b[0]; e_st = b[0];
            end else begin
                e_pend = 1; e_pb = b;
            end
        end else begin
            e_pend = 0; e_spd = b[7:6]; e_pu = b[5]; e_hs = b[4:2];
            e_sl = 0; e_st = 0;
            if (b[1:0] == 2'b10) begin e_mode = 2'b11; e_wd++; end
            else e_mode = b[1:0];
        end
    endtask

    task automatic check_outputs(input string req);
        chk(req, "spd_sel", spd_sel, e_spd);
        chk(req, "pu_off", pu_off, e_pu);
        chk(req, "hs_en", hs_en, e_hs);
        chk(req, "mode_sel", mode_sel, e_mode);
        chk(req, "sleep_req", sleep_req, e_sl);
        chk(req, "stop_req", stop_req, e_st);
        chk(req, "wd pulses", wd_seen, e_wd);
        chk("R12", "miso_en idle", miso_en, 0);
    endtask

    task automatic do_reset(input bit power);
        @(negedge clk);
        if (power) por = 1; else srst = 1;
        repeat (3) @(negedge clk);
        por = 0; srst = 0;
        repeat (4) @(negedge clk);
        e_spd = 0; e_hs = 0; e_mode = 0; e_sl = 0; e_st = 0; e_pend = 0; e_first = 1;
        if (power) e_pu = 0;
    endtask

    localparam int HALF = 6;

    task automatic xfer(input logic [7:0] tx, input int n, input logic [6:0] st,
                        input logic bf, input string req);
        logic [7:0] rx = '0;
        logic [7:0] ex;
        ex = exp_status(st, e_first, bf);
        @(negedge clk);
        stat_src = st; batt_fail = bf;
        repeat (2) @(negedge clk);
        cs_n = 0;
        repeat (HALF) @(negedge clk);
        chk("R12", "miso_en active", miso_en, 1);
        for (int i = 0; i < n; i++) begin
            mosi = (i < 8) ? tx[7-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 8) rx[7-i] = miso;
            sck = 1;
            repeat (HALF) @(negedge clk);
            sck = 0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1;
        repeat (10) @(negedge clk);
        if (n >= 8) chk((e_first ? "R11" : "R10"), "read byte", rx, ex);
        model_frame(n, tx);
        check_outputs(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        repeat (4) @(negedge clk);
        por = 0;
        repeat (4) @(negedge clk);
        check_outputs("R1");

        // directed
        xfer(8'b10_1_101_11, 8, 7'h15, 1'b1, "R2");
        xfer(8'b01_0_011_10, 8, 7'h00, 1'b0, "R3");
        xfer(8'b11_0_000_00, 8, 7'h10, 1'b1, "R4");
        xfer(8'b11_0_000_00, 8, 7'h01, 1'b0, "R5");
        xfer(8'b00_1_111_11, 8, 7'h7f, 1'b0, "R6");
        xfer(8'b11_1_000_01, 8, 7'h10, 1'b0, "R4");
        xfer(8'b11_1_000_01, 8, 7'h00, 1'b1, "R5");
        xfer(8'b11_0_000_01, 8, 7'h02, 1'b0, "R4");
        xfer(8'b11_0_000_00, 8, 7'h02, 1'b0, "R6");
        xfer(8'b11_0_000_00, 7, 7'h04, 1'b0, "R7");
        xfer(8'b11_0_000_00, 8, 7'h04, 1'b0, "R7");
        xfer(8'b11_0_000_00, 9, 7'h08, 1'b0, "R7");
        xfer(8'b01_1_010_11, 8, 7'h08, 1'b0, "R2");
        do_reset(0);
        check_outputs("R8");
        xfer(8'b00_0_001_11, 8, 7'h00, 1'b1, "R11");
        do_reset(1);
        check_outputs("R9");

        // constrained random
        for (int k = 0; k < 250; k++) begin
            int sel = $urandom_range(0, 99);
            logic [7:0] b = 8'($urandom);
            logic [6:0] st = 7'($urandom);
            logic bf = 1'($urandom);
            if (sel < 5) begin do_reset(1); check_outputs("R9"); end
            else if (sel < 12) begin do_reset(0); check_outputs("R8"); end
            else if (sel < 30) begin
                b = {2'b11, b[5], 3'b000, 1'b0, b[0]};
                xfer(b, 8, st, bf, "R4");
                if ($urandom_range(0, 3) == 0) b[5] = ~b[5];
                xfer(b, ($urandom_range(0, 5) == 0) ? 9 : 8, st, bf, "R5");
            end else if (sel < 40) begin
                xfer(b, ($urandom_range(0, 1) == 0) ? 7 : 9, st, bf, "R7");
            end else begin
                xfer(b, 8, st, bf, "R2");
            end
        end

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule